// File: doc/BRIEF.md
# Powered-Device Classification Step-Mask Controller

This block sits inside a powered device and runs the classification phase of a power-over-cable link. Five comparator flags describe where the classification voltage sits: above 15.5 V, above 18 V, above 19 V, above 20.5 V, and below 18.5 V. A slow state-machine tick, nominally 10 kHz, steps a controller through a voltage-and-time mask. The voltage must first settle in the 19 V to 20.5 V band for a fixed hold period. It must then step down within a short window, and afterwards stay in the 15.5 V to 18 V band. A source that follows this mask is an enhanced source.

When the step arrives inside the window, a power timer starts. The timer is a fixed-terminal up-counter driven by a separate programmable-rate tick. When it reaches its terminal count, the block switches off the classification current sink. The time from the step to the cutoff therefore encodes the requested power, and the tick rate selects that time.

A source that never steps is treated as a legacy source. The sink then stays on for as long as the voltage remains in range. Any departure from the mask parks the block in a violation state with the timer frozen. Both tick inputs are clock enables on the single clock `clk`. The comparator flags are expected to be synchronous to `clk` already.

Top module: `pd_step_classifier`

## Requirements
- R1: After reset, and whenever the block is in its reset state, the outputs are `cur_en`=0, `gate`=0, `stop`=1 and `done`=0.
- R2: On a `sm_tick` cycle with `v_gt_15v5`=1, the block leaves reset and enables the sink (`cur_en`=1, `stop`=1, `gate`=0).
- R3: From the sink-enabled state, a tick with `v_gt_19v0`=1 and `v_gt_20v5`=0 starts the hold period (`stop`=0). During the hold period, a tick with `v_gt_19v0`=0 or `v_gt_20v5`=1 is a mask violation.
- R4: The hold period lasts `HOLD_TICKS` ticks (default 80, 8 ms). It is followed by a window of `WIN_TICKS` ticks (default 20) with `gate`=1. A tick in the window with `v_lt_18v5`=1 starts the power timer and enters the post-step band (`gate`=0, `stop`=0).
- R5: In the post-step band, a tick with `v_gt_18v0`=1 is a mask violation.
- R6: In a mask violation, `stop`=1, `gate`=0 and the power timer holds its count. The block stays there until the voltage falls below 15.5 V. The timer can only advance while `stop`=0.
- R7: Once started, the power timer counts `pwr_tick` cycles from 0. `done` rises when the count reaches 2^`TMR_W`-1 (511 by default). While `done`=1, `cur_en`=0.
- R8: If the window closes without a step, the block enters a legacy state with `cur_en`=1, `stop`=1 and `gate`=0, and stays there while the voltage is above 15.5 V.
- R9: A tick during the window with `v_gt_20v5`=1 is a mask violation.
- R10: A tick with `v_gt_15v5`=0 in any state returns the block to reset and clears the timer and `done`. Otherwise `done` is sticky.
- R11: State changes happen only on `sm_tick` cycles. Comparator values on other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sm_tick | input | 1 | State-machine rate enable (nominal 10 kHz) |
| pwr_tick | input | 1 | Programmable-rate enable for the power timer |
| v_gt_15v5 | input | 1 | Voltage above 15.5 V |
| v_gt_18v0 | input | 1 | Voltage above 18 V |
| v_gt_19v0 | input | 1 | Voltage above 19 V |
| v_gt_20v5 | input | 1 | Voltage above 20.5 V |
| v_lt_18v5 | input | 1 | Voltage below 18.5 V |
| cur_en | output | 1 | Classification current sink enable |
| gate | output | 1 | Step window open; a drop below 18.5 V starts the timer |
| stop | output | 1 | Power timer held |
| done | output | 1 | Power timer reached its terminal count |

## Verification
The bench drives the voltage as a level in tenths of a volt and derives all five flags from it.

- A clean mask with a step in the window, run at two timer rates, shows that the cutoff time scales with the timer tick.
- A supply that never steps separates the legacy outcome from a violation.
- Dips below 19 V in the hold period, overshoot above 20.5 V in the window, and a rise above 18 V after the step each show which band check fires in which phase, and that the timer stays frozen.
- A one-cycle dropout between ticks shows that off-tick inputs are ignored.
- Removing the voltage after cutoff shows that `done` clears only through reset.

// File: rtl/pd_cls_pkg.sv
package pd_cls_pkg;
  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_SINK   = 3'd1,
    ST_HOLD   = 3'd2,
    ST_WINDOW = 3'd3,
    ST_BAND   = 3'd4,
    ST_VIOL   = 3'd5,
    ST_LEGACY = 3'd6
  } cls_state_e;
endpackage

// File: rtl/pd_cls_phase_cnt.sv
module pd_cls_phase_cnt #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pd_cls_fsm.sv
module pd_cls_fsm
  import pd_cls_pkg::*;
#(
  parameter int HOLD_TICKS = 80,
  parameter int WIN_TICKS  = 20,
  parameter int CW         = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sm_tick,
  input  logic          v_gt_15v5,
  input  logic          v_gt_18v0,
  input  logic          v_gt_19v0,
  input  logic          v_gt_20v5,
  input  logic          v_lt_18v5,
  input  logic [CW-1:0] ph_cnt,
  output logic          ph_clr,
  output logic          ph_inc,
  output logic          tmr_start,
  output logic          tmr_clr,
  output logic          sink_on,
  output logic          gate,
  output logic          stop
);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] WIN_LAST  = CW'(WIN_TICKS - 1);

  cls_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (sm_tick) begin
      if (!v_gt_15v5) begin
        st_d = ST_RESET;
      end else begin
        unique case (st_q)
          ST_RESET:  st_d = ST_SINK;
          ST_SINK:   if (v_gt_19v0 && !v_gt_20v5) st_d = ST_HOLD;
          ST_HOLD: begin
            if (!v_gt_19v0 || v_gt_20v5) st_d = ST_VIOL;
            else if (ph_cnt == HOLD_LAST) st_d = ST_WINDOW;
          end
          ST_WINDOW: begin
            if (v_gt_20v5)               st_d = ST_VIOL;
            else if (v_lt_18v5)          st_d = ST_BAND;
            else if (ph_cnt == WIN_LAST) st_d = ST_LEGACY;
          end
          ST_BAND:   if (v_gt_18v0) st_d = ST_VIOL;
          ST_VIOL:   st_d = ST_VIOL;
          ST_LEGACY: st_d = ST_LEGACY;
          default:   st_d = ST_RESET;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RESET;
    else        st_q <= st_d;
  end

  always_comb begin
    ph_clr    = sm_tick && (st_d != st_q);
    ph_inc    = sm_tick && ((st_q == ST_HOLD) || (st_q == ST_WINDOW));
    tmr_start = (st_q == ST_WINDOW) && (st_d == ST_BAND);
    tmr_clr   = (st_d == ST_RESET);
    sink_on   = (st_q != ST_RESET);
    gate      = (st_q == ST_WINDOW);
    stop      = (st_q == ST_RESET) || (st_q == ST_SINK) ||
                (st_q == ST_VIOL)  || (st_q == ST_LEGACY);
  end
endmodule

// File: rtl/pd_cls_power_timer.sv
module pd_cls_power_timer #(
  parameter int TMR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  output logic [TMR_W-1:0] cnt,
  output logic             done
);
  localparam logic [TMR_W-1:0] TERM = {TMR_W{1'b1}};

  logic             run_q, run_d, run_en;
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    run_en = clr | start;
    run_d  = ~clr;
    cnt_en = clr | (run_q & ~stop & tick & (cnt_q != TERM));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_en) run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign done = (cnt_q == TERM);
endmodule

// File: rtl/pd_step_classifier.sv
module pd_step_classifier #(
  parameter int HOLD_TICKS = 80,
  parameter int WIN_TICKS  = 20,
  parameter int TMR_W      = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sm_tick,
  input  logic pwr_tick,
  input  logic v_gt_15v5,
  input  logic v_gt_18v0,
  input  logic v_gt_19v0,
  input  logic v_gt_20v5,
  input  logic v_lt_18v5,
  output logic cur_en,
  output logic gate,
  output logic stop,
  output logic done
);
  localparam int PH_MAX = (HOLD_TICKS > WIN_TICKS) ? HOLD_TICKS : WIN_TICKS;
  localparam int CW     = $clog2(PH_MAX + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic [CW-1:0]    ph_cnt;
  logic             ph_clr, ph_inc;
  logic             tmr_start, tmr_clr, sink_on, tmr_done;
  logic [TMR_W-1:0] tmr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  pd_cls_fsm #(
    .HOLD_TICKS(HOLD_TICKS), .WIN_TICKS(WIN_TICKS), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n_i), .sm_tick(sm_tick),
    .v_gt_15v5(v_gt_15v5), .v_gt_18v0(v_gt_18v0), .v_gt_19v0(v_gt_19v0),
    .v_gt_20v5(v_gt_20v5), .v_lt_18v5(v_lt_18v5),
    .ph_cnt(ph_cnt), .ph_clr(ph_clr), .ph_inc(ph_inc),
    .tmr_start(tmr_start), .tmr_clr(tmr_clr),
    .sink_on(sink_on), .gate(gate), .stop(stop)
  );

  pd_cls_phase_cnt #(.CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n_i), .clr(ph_clr), .inc(ph_inc), .cnt(ph_cnt)
  );

  pd_cls_power_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_i), .clr(tmr_clr), .start(tmr_start),
    .stop(stop), .tick(pwr_tick), .cnt(tmr_cnt), .done(tmr_done)
  );

  assign done   = tmr_done;
  assign cur_en = sink_on & ~tmr_done;
endmodule

// File: rtl/pd_cls_checker.sv
module pd_cls_checker #(
  parameter int TMR_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sm_tick,
  input logic             v_gt_15v5,
  input logic             cur_en,
  input logic             gate,
  input logic             stop,
  input logic             done,
  input logic [TMR_W-1:0] tmr_cnt
);
  AST_DONE_CUTS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cur_en); // R7
  AST_GATE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (cur_en && !stop)); // R4
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> ((tmr_cnt == $past(tmr_cnt)) || (tmr_cnt == '0))); // R6
  AST_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!stop)); // R6
  AST_DROPOUT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_tick && !v_gt_15v5) |=> (!cur_en && !done && stop && !gate)); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && v_gt_15v5) |=> done); // R10
  AST_TICK_ONLY_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    !sm_tick |=> ($stable(gate) && $stable(stop))); // R11
endmodule

bind pd_step_classifier pd_cls_checker #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sm_tick(sm_tick), .v_gt_15v5(v_gt_15v5),
  .cur_en(cur_en), .gate(gate), .stop(stop), .done(done), .tmr_cnt(tmr_cnt)
);

// File: tb/tb_pd_step_classifier.sv
module tb_pd_step_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int SM_DIV     = 2;
  localparam int HOLD       = 80;
  localparam int WIN        = 20;
  localparam int TERM       = 511;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   vdec = 0;
  int   pdiv = 1;
  int   cyc = 0;
  int   pcnt = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   ended = 1'b0;

  logic sm_tick, pwr_tick;
  logic f155, f180, f190, f205, fl185;
  logic cur_en, gate, stop, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sm_tick  = (cyc % SM_DIV) == 0;
  assign pwr_tick = (pcnt == 0);
  assign f155  = vdec > 155;
  assign f180  = vdec > 180;
  assign f190  = vdec > 190;
  assign f205  = vdec > 205;
  assign fl185 = vdec < 185;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    pcnt <= (pcnt + 1 >= pdiv) ? 0 : pcnt + 1;
  end

  pd_step_classifier dut (
    .clk(clk), .rst_n(rst_n), .sm_tick(sm_tick), .pwr_tick(pwr_tick),
    .v_gt_15v5(f155), .v_gt_18v0(f180), .v_gt_19v0(f190),
    .v_gt_20v5(f205), .v_lt_18v5(fl185),
    .cur_en(cur_en), .gate(gate), .stop(stop), .done(done)
  );

  // Reference model. Phases: 0 reset, 1 sink on, 2 hold, 3 window,
  // 4 post-step band, 5 violation, 6 legacy.
  int m_st = 0, m_ph = 0, m_cnt = 0;
  bit m_run = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_cnt = 0; m_run = 1'b0;
    end else begin
      automatic int  ns = m_st;
      automatic bit  held = (m_st == 0) || (m_st == 1) || (m_st >= 5);
      if (sm_tick) begin
        if (vdec <= 155) ns = 0;
        else if (m_st == 0) ns = 1;
        else if (m_st == 1) begin
          if (vdec > 190 && vdec <= 205) ns = 2;
        end else if (m_st == 2) begin
          if (vdec <= 190 || vdec > 205) ns = 5;
          else if (m_ph == HOLD - 1) ns = 3;
        end else if (m_st == 3) begin
          if (vdec > 205) ns = 5;
          else if (vdec < 185) ns = 4;
          else if (m_ph == WIN - 1) ns = 6;
        end else if (m_st == 4) begin
          if (vdec > 180) ns = 5;
        end
      end
      if (ns == 0) begin
        m_cnt = 0; m_run = 1'b0;
      end else begin
        if (m_run && !held && pwr_tick && m_cnt < TERM) m_cnt++;
        if (m_st == 3 && ns == 4) m_run = 1'b1;
      end
      if (sm_tick && ns != m_st) m_ph = 0;
      else if (sm_tick && (m_st == 2 || m_st == 3)) m_ph++;
      m_st = ns;
    end
  end

  task automatic expect_bit(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      automatic logic e_done = (m_cnt == TERM);
      expect_bit(gate,   (m_st == 3), "R4 gate vs model");
      expect_bit(stop,   (m_st <= 1) || (m_st >= 5), "R6 stop vs model");
      expect_bit(done,   e_done, "R7 done vs model");
      expect_bit(cur_en, (m_st != 0) && !e_done, "R2 cur_en vs model");
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * SM_DIV) @(negedge clk);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    end
  endtask

  task automatic power_off();
    vdec = 0;
    wait_ticks(3);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_bit(cur_en, 1'b0, "R1 reset cur_en");
    expect_bit(stop,   1'b1, "R1 reset stop");
    expect_bit(gate,   1'b0, "R1 reset gate");
    expect_bit(done,   1'b0, "R1 reset done");

    // R2 then clean step, fast timer
    vdec = 170; wait_ticks(3);
    expect_bit(cur_en, 1'b1, "R2 sink on");
    expect_bit(stop,   1'b1, "R2 stop held");
    vdec = 200; wait_ticks(5);
    expect_bit(stop, 1'b0, "R3 hold entered");
    wait_ticks(HOLD);
    expect_bit(gate, 1'b1, "R4 window open");
    vdec = 170; wait_ticks(2);
    expect_bit(gate, 1'b0, "R4 step taken");
    expect_bit(cur_en, 1'b1, "R4 sink during timing");
    repeat (530) @(negedge clk);
    expect_bit(done,   1'b1, "R7 done fast");
    expect_bit(cur_en, 1'b0, "R7 cutoff");
    vdec = 165; wait_ticks(5);
    expect_bit(done, 1'b1, "R10 done sticky");
    power_off();
    expect_bit(done, 1'b0, "R10 done cleared");
    expect_bit(stop, 1'b1, "R1 back to reset");

    // R8 legacy source
    vdec = 200; wait_ticks(2 + HOLD + WIN + 5);
    expect_bit(stop,   1'b1, "R8 legacy stop");
    expect_bit(gate,   1'b0, "R8 legacy gate");
    expect_bit(cur_en, 1'b1, "R8 legacy sink");
    power_off();

    // R3 hold-period dip, R6 frozen timer
    vdec = 200; wait_ticks(10);
    vdec = 188; wait_ticks(2);
    expect_bit(stop, 1'b1, "R3 dip violation");
    vdec = 200; wait_ticks(HOLD);
    expect_bit(gate, 1'b0, "R6 violation keeps gate low");
    vdec = 170; repeat (600) @(negedge clk);
    expect_bit(done, 1'b0, "R6 no timing after violation");
    power_off();

    // R9 overshoot in window
    vdec = 200; wait_ticks(2 + HOLD + 3);
    vdec = 210; wait_ticks(2);
    expect_bit(stop, 1'b1, "R9 window overshoot");
    expect_bit(gate, 1'b0, "R9 gate closed");
    power_off();

    // R5 post-step rise, R6 timer holds
    vdec = 200; wait_ticks(2 + HOLD + 3);
    vdec = 170; repeat (50) @(negedge clk);
    vdec = 183; wait_ticks(2);
    expect_bit(stop, 1'b1, "R5 band violation");
    repeat (1000) @(negedge clk);
    expect_bit(done, 1'b0, "R6 timer held");
    power_off();

    // R7 slower timer rate
    pdiv = 3;
    vdec = 200; wait_ticks(2 + HOLD + 3);
    vdec = 170;
    repeat (1450) @(negedge clk);
    expect_bit(done, 1'b0, "R7 slow not yet");
    repeat (150) @(negedge clk);
    expect_bit(done, 1'b1, "R7 slow done");
    power_off();
    pdiv = 1;

    // R11 off-tick dropout
    vdec = 200; wait_ticks(10);
    @(negedge clk);
    while (sm_tick) @(negedge clk);
    vdec = 0;
    @(negedge clk);
    vdec = 200;
    wait_ticks(2);
    expect_bit(stop,   1'b0, "R11 glitch ignored");
    expect_bit(cur_en, 1'b1, "R11 sink kept");
    power_off();

    summary();
    $finish;
  end
endmodule